// File: doc/BRIEF.md
# Reset Source Discriminator

This block watches two internal reset requests: a watchdog timeout and a clock-failure alarm. When either one fires, it pulls an open-drain, active-low reset pin low. It holds the pin low for a fixed number of bus-clock (E) ticks and then lets go. A fixed number of E ticks later it looks at the pin again. If some outside agent is still holding the pin low, the reset is recorded as external. If the pin has risen, the reset is recorded as internal, and a flag names the source that caused it.

A low level on the pin with no internal request behind it is also treated as an external reset. The system reset output stays asserted for the whole drive and settle window. In the external case it stays asserted until the pin is seen high. The latched cause flags are then available to the logic that chooses the reset vector. The pin level comes in already synchronised to `clk`. `e_en` is a single-cycle enable that marks each E tick.

Top module: `rst_src_disc`

## Requirements
- R1: After the power-on reset `rst_n` is released, `pin_drive_low`, `sys_rst`, `cause_ext`, `cause_wdog` and `cause_clkmon` are all 0.
- R2: While idle, a watchdog or clock-failure request sampled on a clock edge gives `pin_drive_low`=1 and `sys_rst`=1 from the following cycle. The request wins even if the pin is low at that moment.
- R3: The pin is driven low for exactly DRIVE_TICKS E ticks (default 4), counted from the cycle after the request. `pin_drive_low` falls on the edge that takes the last of those ticks.
- R4: After the release, the pin level is sampled on the edge that takes the SETTLE_TICKS-th E tick (default 2). `sys_rst` stays 1 and `pin_drive_low` stays 0 until that edge.
- R5: If the sampled pin is high, `sys_rst` falls on that edge. Exactly one of `cause_wdog` or `cause_clkmon` is set, matching the request that started the sequence, and `cause_ext` is cleared.
- R6: If the sampled pin is low, `cause_ext` is set and the other flags are cleared. `sys_rst` stays 1 until the pin is seen high, and falls on the edge that sees it high.
- R7: While idle, a low pin with no request gives `sys_rst`=1 and `cause_ext`=1 from the next cycle. `pin_drive_low` stays 0 throughout.
- R8: If the watchdog and clock-failure requests arrive in the same cycle, the clock-failure source is recorded.
- R9: Requests that arrive while a sequence or an external hold is in progress are ignored. The sequence does not restart, the recorded cause is that of the starting request, and no new drive follows once the block is idle again.
- R10: The cause flags keep their value while idle with the pin high until the next classification, and the block stays idle meanwhile.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Power-on reset, active low |
| e_en | input | 1 | One-cycle pulse marking each E-clock tick |
| wdog_req | input | 1 | Watchdog timeout reset request |
| clkmon_req | input | 1 | Clock-failure reset request |
| pin_in | input | 1 | Synchronised level of the reset pin (0 = low) |
| pin_drive_low | output | 1 | Enables the open-drain pull-down on the reset pin |
| sys_rst | output | 1 | System reset to the rest of the chip |
| cause_ext | output | 1 | Last reset was classified as external |
| cause_wdog | output | 1 | Last reset was caused by the watchdog |
| cause_clkmon | output | 1 | Last reset was caused by the clock-failure alarm |

## Verification
The assertions check several things on every cycle. The drive length is checked against an independent tick counter. An idle request must start the drive on the next cycle. `sys_rst` must never drop while the pin is driven or held low externally. At most one cause flag may be set. An internal cause may only appear after a high pin sample.

Other behaviour only shows up in the bench's scenarios. These include the settle-tick count before the sample, the source priority, and the way noise requests are ignored during a sequence. The bench also covers the external-hold release and how long the flags are retained. It drives these through random E-tick spacing and a wired pin model.

// File: rtl/rsd_pkg.sv
package rsd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_DRIVE   = 2'd1,
    ST_SETTLE  = 2'd2,
    ST_EXTHOLD = 2'd3
  } rsd_state_e;

  typedef enum logic [1:0] {
    SRC_NONE   = 2'd0,
    SRC_WDOG   = 2'd1,
    SRC_CLKMON = 2'd2,
    SRC_EXT    = 2'd3
  } rsd_src_e;

  // Clock-failure alarm outranks the watchdog (R8)
  function automatic rsd_src_e pick_internal(input logic wdog, input logic clkmon);
    if (clkmon)    return SRC_CLKMON;
    else if (wdog) return SRC_WDOG;
    else           return SRC_NONE;
  endfunction

  // Flag vector layout: {ext, clkmon, wdog}
  function automatic logic [2:0] flags_of(input rsd_src_e src);
    case (src)
      SRC_WDOG:   return 3'b001;
      SRC_CLKMON: return 3'b010;
      SRC_EXT:    return 3'b100;
      default:    return 3'b000;
    endcase
  endfunction

endpackage

// File: rtl/rsd_phase_cnt.sv
module rsd_phase_cnt #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         tick,
  input  logic [W-1:0] limit,
  output logic         last
);
  logic [W-1:0] cnt;

  assign last = tick && (cnt == limit - W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (clear)  cnt <= '0;
    else if (last)   cnt <= '0;
    else if (tick)   cnt <= cnt + W'(1);
  end
endmodule

// File: rtl/rsd_fsm.sv
module rsd_fsm
  import rsd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_any,
  input  logic       pin_in,
  input  logic       phase_last,
  output rsd_state_e state,
  output logic       start_seq,
  output logic       classify_int,
  output logic       classify_ext
);
  rsd_state_e nxt;

  always_comb begin
    nxt          = state;
    start_seq    = 1'b0;
    classify_int = 1'b0;
    classify_ext = 1'b0;
    case (state)
      ST_IDLE: begin
        if (req_any) begin
          nxt       = ST_DRIVE;
          start_seq = 1'b1;
        end else if (!pin_in) begin
          nxt          = ST_EXTHOLD;
          classify_ext = 1'b1;
        end
      end
      ST_DRIVE: if (phase_last) nxt = ST_SETTLE;
      ST_SETTLE: begin
        if (phase_last) begin
          if (pin_in) begin
            nxt          = ST_IDLE;
            classify_int = 1'b1;
          end else begin
            nxt          = ST_EXTHOLD;
            classify_ext = 1'b1;
          end
        end
      end
      ST_EXTHOLD: if (pin_in) nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end

  // R7
  // an unrequested low pin seen while idle must lead into the external hold
  ext_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && !req_any && !pin_in) |=> (state == ST_EXTHOLD));
endmodule

// File: rtl/rsd_cause.sv
module rsd_cause
  import rsd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_seq,
  input  logic       wdog_req,
  input  logic       clkmon_req,
  input  logic       classify_int,
  input  logic       classify_ext,
  output logic [2:0] flags
);
  rsd_src_e pending;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending <= SRC_NONE;
      flags   <= '0;
    end else begin
      if (start_seq)    pending <= pick_internal(wdog_req, clkmon_req);
      if (classify_int) flags   <= flags_of(pending);
      else if (classify_ext) flags <= flags_of(SRC_EXT);
    end
  end

  // R5
  cause_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(flags));
endmodule

// File: rtl/rst_src_disc.sv
module rst_src_disc
  import rsd_pkg::*;
#(
  parameter int DRIVE_TICKS  = 4,
  parameter int SETTLE_TICKS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic e_en,
  input  logic wdog_req,
  input  logic clkmon_req,
  input  logic pin_in,
  output logic pin_drive_low,
  output logic sys_rst,
  output logic cause_ext,
  output logic cause_wdog,
  output logic cause_clkmon
);
  localparam int MAXT  = (DRIVE_TICKS > SETTLE_TICKS) ? DRIVE_TICKS : SETTLE_TICKS;
  localparam int CNT_W = $clog2(MAXT + 1);

  rsd_state_e   state;
  logic         start_seq, classify_int, classify_ext;
  logic         phase_last, in_phase, req_any;
  logic [CNT_W-1:0] phase_limit;
  logic [2:0]   flags;

  assign req_any     = wdog_req | clkmon_req;
  assign in_phase    = (state == ST_DRIVE) || (state == ST_SETTLE);
  assign phase_limit = (state == ST_DRIVE) ? CNT_W'(DRIVE_TICKS) : CNT_W'(SETTLE_TICKS);

  rsd_phase_cnt #(.W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (!in_phase),
    .tick  (e_en && in_phase),
    .limit (phase_limit),
    .last  (phase_last)
  );

  rsd_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_any      (req_any),
    .pin_in       (pin_in),
    .phase_last   (phase_last),
    .state        (state),
    .start_seq    (start_seq),
    .classify_int (classify_int),
    .classify_ext (classify_ext)
  );

  rsd_cause u_cause (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_seq    (start_seq),
    .wdog_req     (wdog_req),
    .clkmon_req   (clkmon_req),
    .classify_int (classify_int),
    .classify_ext (classify_ext),
    .flags        (flags)
  );

  assign pin_drive_low = (state == ST_DRIVE);
  assign sys_rst       = (state != ST_IDLE);
  assign cause_wdog    = flags[0];
  assign cause_clkmon  = flags[1];
  assign cause_ext     = flags[2];

  // Independent tally of E ticks seen while the pin is driven
  logic [CNT_W-1:0] chk_ticks;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              chk_ticks <= '0;
    else if (!pin_drive_low) chk_ticks <= '0;
    else if (e_en)           chk_ticks <= chk_ticks + CNT_W'(1);
  end

  // R3
  drive_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pin_drive_low) |-> ($past(e_en) && $past(chk_ticks) == CNT_W'(DRIVE_TICKS - 1)));

  // R2
  idle_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sys_rst && req_any) |=> pin_drive_low);

  // R4
  window_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pin_drive_low |=> sys_rst);

  // R6
  ext_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cause_ext && sys_rst && !pin_in) |=> sys_rst);

  // R5
  int_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cause_wdog) || $rose(cause_clkmon)) |-> $past(pin_in));
endmodule

// File: tb/tb_rst_src_disc.sv
module tb_rst_src_disc;
  localparam int DRV = 4;
  localparam int STL = 2;

  logic clk = 1'b0;
  logic rst_n, e_en, wdog_req, clkmon_req, ext_hold;
  logic pin_in, pin_drive_low, sys_rst, cause_ext, cause_wdog, cause_clkmon;
  int   tests = 0, fails = 0;
  bit   done  = 0;

  always #5 clk = ~clk;

  // wired open-drain pin: low if the block or the outside agent pulls it
  assign pin_in = !(pin_drive_low || ext_hold);

  rst_src_disc dut (
    .clk(clk), .rst_n(rst_n), .e_en(e_en), .wdog_req(wdog_req),
    .clkmon_req(clkmon_req), .pin_in(pin_in), .pin_drive_low(pin_drive_low),
    .sys_rst(sys_rst), .cause_ext(cause_ext), .cause_wdog(cause_wdog),
    .cause_clkmon(cause_clkmon)
  );

  function automatic logic [2:0] exp_flags(input bit w, input bit c, input bit ext);
    if (ext) return 3'b100;
    if (c)   return 3'b010;
    if (w)   return 3'b001;
    return 3'b000;
  endfunction

  function automatic logic [2:0] got_flags();
    return {cause_ext, cause_clkmon, cause_wdog};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit rnd_tick();
    return ($urandom_range(0, 2) == 0);
  endfunction

  // one internal sequence; ext keeps the pin low, noise injects requests mid-sequence
  task automatic run_seq(input bit w, input bit c, input bit ext, input bit noise);
    int dticks = 0, sticks = 0;
    @(negedge clk);
    wdog_req = w; clkmon_req = c; ext_hold = ext; e_en = rnd_tick();
    @(negedge clk);
    wdog_req = 0; clkmon_req = 0;
    check("R2 drive starts", {pin_drive_low, sys_rst}, 2'b11);
    while (pin_drive_low && dticks <= DRV + 1) begin
      check("R4 sys_rst during drive", sys_rst, 1);
      e_en = rnd_tick();
      if (e_en) dticks++;
      wdog_req   = noise ? 1'($urandom_range(0, 1)) : 1'b0;
      clkmon_req = noise ? 1'($urandom_range(0, 1)) : 1'b0;
      @(negedge clk);
    end
    check("R3 drive tick count", dticks, DRV);
    while (sticks < STL) begin
      check("R4 settle window", {sys_rst, pin_drive_low}, 2'b10);
      e_en = rnd_tick();
      if (e_en) sticks++;
      wdog_req   = noise ? 1'($urandom_range(0, 1)) : 1'b0;
      clkmon_req = noise ? 1'($urandom_range(0, 1)) : 1'b0;
      @(negedge clk);
    end
    wdog_req = 0; clkmon_req = 0; e_en = 0;
    if (ext) begin
      check("R6 ext classification", {sys_rst, got_flags()}, {1'b1, 3'b100});
      repeat (3) begin
        e_en = rnd_tick();
        @(negedge clk);
        check("R6 held while pin low", {sys_rst, pin_drive_low}, 2'b10);
      end
      ext_hold = 0;
      @(negedge clk);
      check("R6 release on pin high", sys_rst, 0);
    end else begin
      check(c ? "R8/R5 int classification" : "R5 int classification",
            {sys_rst, got_flags()}, {1'b0, exp_flags(w, c, 0)});
    end
    repeat (3) begin
      e_en = rnd_tick();
      @(negedge clk);
      check("R9 no drive after sequence", {pin_drive_low, sys_rst}, 2'b00);
    end
    check("R10 flags retained", got_flags(), exp_flags(w, c, ext));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_2024));
    rst_n = 0; e_en = 0; wdog_req = 0; clkmon_req = 0; ext_hold = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 reset state", {pin_drive_low, sys_rst, got_flags()}, 5'b0);

    // directed corners
    run_seq(1, 0, 0, 0);            // watchdog, internal
    run_seq(0, 1, 0, 0);            // clock alarm, internal
    run_seq(1, 1, 0, 0);            // simultaneous: R8
    run_seq(1, 0, 1, 0);            // request while pin held low: R2/R6
    run_seq(1, 0, 0, 1);            // noise during sequence: R9

    // R7 pure external reset, requests during hold ignored
    @(negedge clk); ext_hold = 1;
    @(negedge clk);
    check("R7 ext entry", {pin_drive_low, sys_rst, got_flags()}, {2'b01, 3'b100});
    repeat (4) begin
      wdog_req = 1'($urandom_range(0, 1)); clkmon_req = 1'($urandom_range(0, 1));
      e_en = rnd_tick();
      @(negedge clk);
      check("R9 ignored during ext hold", {pin_drive_low, sys_rst}, 2'b01);
    end
    wdog_req = 0; clkmon_req = 0; ext_hold = 0;
    @(negedge clk);
    check("R7 leave ext hold", sys_rst, 0);
    check("R7 flags", got_flags(), 3'b100);

    // constrained random sequences
    for (int i = 0; i < 40; i++) begin
      bit w, c;
      w = 1'($urandom_range(0, 1));
      c = 1'($urandom_range(0, 1));
      if (!w && !c) w = 1;
      run_seq(w, c, ($urandom_range(0, 3) == 0), 1'($urandom_range(0, 1)));
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule